// File: doc/BRIEF.md
# Fractional-N Feedback Divide Controller

This block decides, once per comparison cycle, how many VCO cycles the feedback divider of a fractional-N PLL counts before it produces its next edge. Software supplies an 8-bit integer part and a 28-bit fraction. Over many comparison cycles, the mean of the divide values the block issues is the integer plus the fraction divided by 2^28. A three-stage cascade of 28-bit accumulators spreads the fractional carries so that their quantisation error is pushed to high offset frequencies.

The reference and VCO clocks arrive as single-cycle enable pulses in the fast clock domain. A predivider thins the reference pulses by 1 to 4 to form the comparison tick. A loadable down-counter counts VCO pulses and emits the feedback tick. A lock monitor compares the two ticks. An integer-only control freezes the fractional machinery so that the divider counts by the integer part alone. All control inputs are sampled only on a comparison tick, so a change made partway through an update is never used.

Top module: `fracn_divctl`

## Requirements
- R1: After reset, `div_value` is 177, and `lock`, `cmp_tick` and `fb_tick` are 0.
- R2: On each comparison tick with `int_mode`=0, three 28-bit accumulators update in a chain: stage 1 adds `frac_word`, and stages 2 and 3 each add the new residue of the stage before. Their carries c1, c2 and c3 form y = c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' means the value from the previous tick. `div_value` becomes the clamped N plus y. Over K ticks, the sum of (`div_value` − N) is within 4 of K·F/2^28.
- R3: An `n_word` below 35 is used as 35, and one above 251 is used as 251.
- R4: `div_value` always lies between 32 and 255 inclusive.
- R5: `rdiv_code` c (2'b00..2'b11) divides the reference by c+1. An internal counter advances on each `ref_en`. When the counter is already ≥ c, it restarts at 0, and `cmp_tick` is high for the one cycle after that `ref_en`.
- R6: `n_word`, `frac_word` and `int_mode` are sampled only on a clock where `cmp_tick` is high. `div_value` changes only on the clock after a `cmp_tick` and holds at all other times.
- R7: With `int_mode`=1, a tick leaves the accumulators unchanged, clears the delayed carries, and sets `div_value` to the clamped N.
- R8: The feedback counter starts at 1 after reset and decrements on each `vco_en`. A `vco_en` that arrives while the count is 1 reloads the counter from `div_value` and makes `fb_tick` high for the next cycle.
- R9: A hit is a `cmp_tick` and an `fb_tick` in the same cycle or in adjacent cycles. An unpaired tick left over for one cycle is a miss. `lock` rises on the cycle after the 32nd consecutive hit, and falls on the cycle after the first miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | One pulse per reference cycle |
| vco_en | input | 1 | One pulse per VCO cycle |
| n_word | input | 8 | Integer part of the division ratio |
| frac_word | input | 28 | Fraction numerator over 2^28 |
| rdiv_code | input | 2 | Reference predivide code (ratio = code+1) |
| int_mode | input | 1 | 1 = integer-only division |
| div_value | output | 8 | Current instantaneous divide value |
| cmp_tick | output | 1 | Comparison tick after the predivider |
| fb_tick | output | 1 | Feedback divider terminal tick |
| lock | output | 1 | Lock indication |

## Verification
The hardest condition to reach from the ports is lock. It needs 32 comparison periods in a row in which the last VCO pulse of each divide count falls on the same fast-clock cycle as the reference pulse. The stimulus first puts the block in integer mode, so that every count has a known length. It then fires one lone VCO pulse to align the feedback counter. After that, it issues the count minus one VCO pulses, followed by the final VCO pulse driven together with the reference pulse. One deliberately late period then shows that lock is lost. Fractional sequences are compared tick by tick against an accumulator model kept in the bench, and a long run is checked against the expected mean ratio.

// File: rtl/fracn_pkg.sv
// Shared constants and helpers for the fractional-N divide controller.
package fracn_pkg;
    localparam int FRAC_W    = 28;
    localparam int N_W       = 8;
    localparam int RDIV_W    = 2;
    localparam int N_MIN     = 35;
    localparam int N_MAX     = 251;
    localparam int N_RST     = 177;
    localparam int LOCK_HITS = 32;
    localparam int MASH_ORD  = 3;

    // Bring an integer part into the legal range.
    function automatic logic [N_W-1:0] clamp_n(input logic [N_W-1:0] n);
        if (n < N_W'(N_MIN))      return N_W'(N_MIN);
        else if (n > N_W'(N_MAX)) return N_W'(N_MAX);
        else                      return n;
    endfunction
endpackage

// File: rtl/fracn_refdiv.sv
// Reference predivider: passes one of every (code+1) reference pulses as a
// one-cycle comparison tick. Assumes ref_en pulses are one fast cycle wide.
module fracn_refdiv #(
    parameter int RDIV_W = fracn_pkg::RDIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic [RDIV_W-1:0] code,
    output logic              tick
);
    logic [RDIV_W-1:0] cnt;

    // Count reference pulses and restart once the code is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (ref_en) begin
            if (cnt >= code) begin
                cnt  <= '0;
                tick <= 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/fracn_mash.sv
// Third-order cascaded accumulator modulator. Each stage adds the new residue
// of the stage before it. y_next is the carry combination that the next step
// produces. State advances only on step. With hold set, the accumulators keep
// their values and the carry delays clear.
module fracn_mash #(
    parameter int FRAC_W = fracn_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              hold,
    input  logic [FRAC_W-1:0] frac,
    output logic signed [3:0] y_next
);
    localparam int ORD = fracn_pkg::MASH_ORD;

    logic [FRAC_W-1:0] acc [ORD];
    logic [FRAC_W:0]   sum [ORD];
    logic [ORD-1:0]    cy;
    logic              c2_d, c3_d, c3_dd;

    for (genvar g = 0; g < ORD; g++) begin : g_stage
        // Form this stage's sum from its own residue and the input below it.
        if (g == 0) begin : g_first
            always_comb sum[g] = {1'b0, acc[g]} + {1'b0, frac};
        end else begin : g_next
            always_comb sum[g] = {1'b0, acc[g]} + {1'b0, sum[g-1][FRAC_W-1:0]};
        end
        assign cy[g] = sum[g][FRAC_W];

        // Commit this stage's residue on each unfrozen step.
        always_ff @(posedge clk) begin
            if (!rst_n)            acc[g] <= '0;
            else if (step && !hold) acc[g] <= sum[g][FRAC_W-1:0];
        end
    end

    // Differentiate the carries of the later stages and sum them.
    always_comb begin
        if (hold) begin
            y_next = 4'sd0;
        end else begin
            y_next = $signed({3'b000, cy[0]})
                   + $signed({3'b000, cy[1]}) - $signed({3'b000, c2_d})
                   + $signed({3'b000, cy[2]}) - $signed({2'b00, c3_d, 1'b0})
                   + $signed({3'b000, c3_dd});
        end
    end

    // Keep the carry history the differentiators need.
    always_ff @(posedge clk) begin
        if (!rst_n || (step && hold)) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (step) begin
            c2_d  <= cy[1];
            c3_d  <= cy[2];
            c3_dd <= c3_d;
        end
    end
endmodule

// File: rtl/fracn_fbdiv.sv
// Feedback divider modelled as a loadable down-counter of VCO pulses.
// On terminal count it reloads from the divide value and emits one tick.
module fracn_fbdiv #(
    parameter int N_W = fracn_pkg::N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_en,
    input  logic [N_W-1:0] load_val,
    output logic           tick
);
    logic [N_W-1:0] cnt;

    // Count VCO pulses down and reload at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= N_W'(1);
            tick <= 1'b0;
        end else if (vco_en) begin
            if (cnt <= N_W'(1)) begin
                cnt  <= load_val;
                tick <= 1'b1;
            end else begin
                cnt  <= cnt - 1'b1;
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/fracn_lockdet.sv
// Lock monitor: pairs comparison and feedback ticks that land in the same or
// adjacent fast cycles. Consecutive pairs are counted, and any unpaired tick
// clears the count.
module fracn_lockdet #(
    parameter int LOCK_HITS = fracn_pkg::LOCK_HITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic lock
);
    localparam int CW = $clog2(LOCK_HITS);

    logic          pend_ref, pend_fb, hit, miss;
    logic [CW-1:0] hits;

    // Decide whether this cycle closes a pair or lets a lone tick expire.
    always_comb begin
        hit  = (ref_tick & fb_tick) | (ref_tick & pend_fb) | (fb_tick & pend_ref);
        miss = (pend_ref & ~fb_tick) | (pend_fb & ~ref_tick);
    end

    // Track unpaired ticks and the run of consecutive hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ref <= 1'b0;
            pend_fb  <= 1'b0;
            hits     <= '0;
            lock     <= 1'b0;
        end else begin
            pend_ref <= ref_tick & ~fb_tick & ~pend_fb;
            pend_fb  <= fb_tick & ~ref_tick & ~pend_ref;
            if (miss) begin
                hits <= '0;
                lock <= 1'b0;
            end else if (hit) begin
                if (hits == CW'(LOCK_HITS - 1)) lock <= 1'b1;
                else                             hits <= hits + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fracn_divctl.sv
// Fractional-N divide controller top. Samples the control words on each
// comparison tick and issues the clamped N plus the modulator correction.
// The predivider, feedback counter and lock monitor are instantiated here.
module fracn_divctl #(
    parameter int FRAC_W    = fracn_pkg::FRAC_W,
    parameter int N_W       = fracn_pkg::N_W,
    parameter int RDIV_W    = fracn_pkg::RDIV_W,
    parameter int LOCK_HITS = fracn_pkg::LOCK_HITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              vco_en,
    input  logic [N_W-1:0]    n_word,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic [RDIV_W-1:0] rdiv_code,
    input  logic              int_mode,
    output logic [N_W-1:0]    div_value,
    output logic              cmp_tick,
    output logic              fb_tick,
    output logic              lock
);
    logic signed [3:0] y_next;
    logic [N_W-1:0]    n_cl;

    fracn_refdiv #(.RDIV_W(RDIV_W)) u_refdiv (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .code(rdiv_code), .tick(cmp_tick)
    );

    fracn_mash #(.FRAC_W(FRAC_W)) u_mash (
        .clk(clk), .rst_n(rst_n), .step(cmp_tick), .hold(int_mode),
        .frac(frac_word), .y_next(y_next)
    );

    fracn_fbdiv #(.N_W(N_W)) u_fbdiv (
        .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .load_val(div_value), .tick(fb_tick)
    );

    fracn_lockdet #(.LOCK_HITS(LOCK_HITS)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_tick(cmp_tick), .fb_tick(fb_tick), .lock(lock)
    );

    // Clamp the requested integer part into its legal range.
    always_comb n_cl = fracn_pkg::clamp_n(n_word);

    // Update the divide value only at a comparison boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_value <= N_W'(fracn_pkg::N_RST);
        else if (cmp_tick) div_value <= n_cl + {{(N_W-4){y_next[3]}}, y_next};
    end
endmodule

// File: rtl/fracn_divctl_chk.sv
// Property checker for fracn_divctl, attached to it by bind.
module fracn_divctl_chk #(
    parameter int N_W    = fracn_pkg::N_W,
    parameter int RDIV_W = fracn_pkg::RDIV_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_en,
    input logic              vco_en,
    input logic [N_W-1:0]    n_word,
    input logic              int_mode,
    input logic [RDIV_W-1:0] rdiv_code,
    input logic [N_W-1:0]    div_value,
    input logic              cmp_tick,
    input logic              fb_tick,
    input logic              lock
);
    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_value >= N_W'(32));

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmp_tick) |-> $stable(div_value));

    // R7
    int_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_tick) && $past(int_mode)) |-> div_value == fracn_pkg::clamp_n($past(n_word)));

    // R5
    tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_tick |-> $past(ref_en));

    // R5
    rdiv_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && rdiv_code == '0) |=> cmp_tick);

    // R8
    fb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |-> $past(vco_en));

    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(cmp_tick) || $past(fb_tick)));
endmodule

bind fracn_divctl fracn_divctl_chk u_chk (.*);

// File: tb/tb_fracn_divctl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected divide values, and a monitor
// pops them as the design produces them.
module tb_fracn_divctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0, vco_en = 1'b0, int_mode = 1'b0;
    logic [7:0]  n_word = 8'd86;
    logic [27:0] frac_word = '0;
    logic [1:0]  rdiv_code = 2'b00;
    logic [7:0]  div_value;
    logic        cmp_tick, fb_tick, lock;

    int n_checks = 0, n_errs = 0;
    int exp_q[$];
    string tag_q[$];
    bit chk_next = 0, avg_on = 0;
    longint dut_sum = 0;
    int dmin = 255, dmax = 0;

    // bench model state
    logic [27:0] m_a1 = '0, m_a2 = '0, m_a3 = '0;
    bit m_c2d = 0, m_c3d = 0, m_c3dd = 0;
    int pd_cnt = 0;

    always #5 clk = ~clk;

    fracn_divctl dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp_exp(input int n);
        return (n < 35) ? 35 : (n > 251) ? 251 : n;
    endfunction

    // Expected divide value for one comparison tick (R2, R3, R7).
    task automatic model_step(output int expv);
        logic [28:0] s1, s2, s3;
        int y;
        if (int_mode) begin
            y = 0; m_c2d = 0; m_c3d = 0; m_c3dd = 0;
        end else begin
            s1 = {1'b0, m_a1} + {1'b0, frac_word};
            s2 = {1'b0, m_a2} + {1'b0, s1[27:0]};
            s3 = {1'b0, m_a3} + {1'b0, s2[27:0]};
            y = int'(s1[28]) + int'(s2[28]) - int'(m_c2d)
              + int'(s3[28]) - 2 * int'(m_c3d) + int'(m_c3dd);
            m_a1 = s1[27:0]; m_a2 = s2[27:0]; m_a3 = s3[27:0];
            m_c3dd = m_c3d; m_c3d = s3[28]; m_c2d = s2[28];
        end
        expv = clamp_exp(int'(n_word)) + y;
    endtask

    // Driver: one reference pulse, optionally with a VCO pulse on the same cycle.
    task automatic ref_pulse(input bit with_vco, input string tag, output bit fb_seen);
        bit tick_exp;
        int expv;
        tick_exp = (pd_cnt >= int'(rdiv_code));
        pd_cnt = tick_exp ? 0 : pd_cnt + 1;
        if (tick_exp) begin
            model_step(expv);
            exp_q.push_back(expv);
            tag_q.push_back(tag);
        end
        @(negedge clk); ref_en = 1'b1; vco_en = with_vco;
        @(negedge clk); ref_en = 1'b0; vco_en = 1'b0;
        chk(cmp_tick == tick_exp, "R5 cmp_tick", cmp_tick, tick_exp);
        fb_seen = fb_tick;
        @(negedge clk);
    endtask

    task automatic vco_pulse(output bit fb_seen);
        @(negedge clk); vco_en = 1'b1;
        @(negedge clk); vco_en = 1'b0;
        fb_seen = fb_tick;
    endtask

    // Monitor: compare div_value on the cycle after each comparison tick.
    always @(negedge clk) begin
        if (rst_n && chk_next) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected update", div_value, -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'(div_value) == e, t, div_value, e);
            end
            if (avg_on) dut_sum += longint'(div_value);
            if (int'(div_value) < dmin) dmin = int'(div_value);
            if (int'(div_value) > dmax) dmax = int'(div_value);
        end
        chk_next = cmp_tick;
    end

    // Watchdog.
    initial begin
        #2_000_000;
        n_errs++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        bit fb;
        longint diff;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(div_value == 8'd177, "R1 div_value", div_value, 177);
        chk(lock == 1'b0, "R1 lock", lock, 0);
        chk(cmp_tick == 1'b0, "R1 cmp_tick", cmp_tick, 0);
        chk(fb_tick == 1'b0, "R1 fb_tick", fb_tick, 0);

        // R5 predivider ratios with the 86 + 0xE66666 check case (R2)
        frac_word = 28'd15099494; n_word = 8'd86;
        rdiv_code = 2'b10; for (int i = 0; i < 9; i++) ref_pulse(0, "R2 frac /3", fb);
        rdiv_code = 2'b01; for (int i = 0; i < 6; i++) ref_pulse(0, "R2 frac /2", fb);
        rdiv_code = 2'b11; for (int i = 0; i < 8; i++) ref_pulse(0, "R2 frac /4", fb);

        // R2 long-run mean
        rdiv_code = 2'b00;
        @(negedge clk); avg_on = 1; dut_sum = 0;
        for (int i = 0; i < 1024; i++) ref_pulse(0, "R2 frac seq", fb);
        @(negedge clk); avg_on = 0;
        diff = (dut_sum - 1024 * 86) * (longint'(1) << 28) - 1024 * longint'(15099494);
        if (diff < 0) diff = -diff;
        chk(diff <= (longint'(4) << 28), "R2 mean ratio", dut_sum, 1024 * 86 + 57);

        // R7 integer mode, R6 sampling only at tick
        int_mode = 1'b1; n_word = 8'd100;
        ref_pulse(0, "R7 int div", fb);
        n_word = 8'd120;
        repeat (5) @(negedge clk);
        chk(div_value == 8'd100, "R6 held until tick", div_value, 100);
        ref_pulse(0, "R6 new N at tick", fb);
        // R3 clamping
        n_word = 8'd20;  ref_pulse(0, "R3 clamp low", fb);
        n_word = 8'd255; ref_pulse(0, "R3 clamp high", fb);
        // back to fractional: accumulators resume from held state (R7)
        int_mode = 1'b0;
        for (int i = 0; i < 8; i++) ref_pulse(0, "R7 resume frac", fb);

        // R4 range at both ends
        dmin = 255; dmax = 0;
        n_word = 8'd35; frac_word = 28'h0FFFFFF;
        for (int i = 0; i < 200; i++) ref_pulse(0, "R4 low end", fb);
        n_word = 8'd251; frac_word = 28'h8000001;
        for (int i = 0; i < 200; i++) ref_pulse(0, "R4 high end", fb);
        n_word = 8'd10; frac_word = 28'hAAAAAAA;
        for (int i = 0; i < 100; i++) ref_pulse(0, "R4 clamped low", fb);
        @(negedge clk);
        chk(dmin >= 32, "R4 min", dmin, 32);
        chk(dmax <= 255, "R4 max", dmax, 255);

        // R8 / R9 lock sequence in integer mode, N = 40
        int_mode = 1'b1; n_word = 8'd40;
        ref_pulse(0, "R7 lock setup", fb);
        vco_pulse(fb);
        chk(fb == 1'b1, "R8 first vco tick", fb, 1);
        for (int p = 1; p <= 32; p++) begin
            for (int k = 0; k < 39; k++) begin
                vco_pulse(fb);
                if (p == 1 && k == 38) chk(fb == 1'b0, "R8 no early tick", fb, 0);
            end
            ref_pulse(1, "R7 lock period", fb);
            if (p == 1) chk(fb == 1'b1, "R8 terminal tick", fb, 1);
            if (p == 31) chk(lock == 1'b0, "R9 before 32 hits", lock, 0);
            if (p == 32) chk(lock == 1'b1, "R9 after 32 hits", lock, 1);
        end
        // lone reference tick: first miss drops lock
        ref_pulse(0, "R7 miss period", fb);
        @(negedge clk);
        chk(lock == 1'b0, "R9 drop on miss", lock, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all ticks seen", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule